// File: doc/BRIEF.md
# DMA Request Acceptance Controller

This block serves one DMA channel whose transfer requests arrive as a level-sensitive, active-low signal on an external pin, and whose transfers run in single address mode. Once software enables the channel, the controller looks at the request pin on every rising clock edge. When it sees a low level while acceptance is open, it holds the request internally and raises a bus request toward a simple arbiter.

The arbiter answers with a grant, which the controller treats as the bus break. At that edge the held request is cleared and a fixed-length single-address cycle starts. During that cycle the active-low acknowledge strobe tells the external device to act as source or destination. When the cycle ends, the bus request is released and acceptance opens again.

Each completed cycle decrements a transfer counter. When the counter reaches zero, the channel disables itself and raises a done flag. Writing a disable clears any held request. A transfer already under way is allowed to finish.

Top module: `dma_req_accept`

## Requirements
- R1: After reset, busReq is 0, dackN is 1 and done is 0.
- R2: A low on dreqN is accepted only while the channel is enabled, levelMode is 1 and srcPin is 1. In any other case a low on dreqN never raises busReq.
- R3: An enabling write (cfgWr=1, cfgEn=1 in one cycle) takes effect at the rising edge that ends that cycle. The pin is first sampled at the next rising edge, so busReq rises after the second edge following the write cycle and not after the first.
- R4: An accepted request is held. busReq stays 1 and dackN stays 1 for as long as no grant arrives, even after dreqN returns high.
- R5: A grant sampled while a request is held clears that request. dackN goes low after that same edge.
- R6: dackN stays low for exactly XFER_CYC cycles (default 2). busReq is 1 throughout and drops when the cycle ends.
- R7: Acceptance is closed from the grant edge until the transfer completes. With dreqN held low, exactly two cycles with dackN high separate consecutive transfers.
- R8: Each completed transfer decrements the counter loaded by the enabling write. After that many transfers, done is 1 and no further busReq is raised, even if dreqN stays low.
- R9: An enabling write with a zero count does not enable the channel. It sets done, and no busReq follows.
- R10: A disabling write (cfgWr=1, cfgEn=0) while a request is held drops busReq by the second rising edge after the write cycle. No transfer occurs.
- R11: A disabling write during a transfer lets that transfer run its full length. After it, no new request is accepted.
- R12: An enabling write with a nonzero count clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Control write strobe, one cycle |
| cfgEn | input | 1 | Enable value carried by the write |
| cfgCount | input | CNT_W | Transfer count loaded by an enabling write |
| levelMode | input | 1 | 1 selects level-sensitive activation |
| srcPin | input | 1 | 1 selects the external pin as request source |
| dreqN | input | 1 | External request, active low |
| busGrant | input | 1 | Grant from the bus arbiter (bus break) |
| busReq | output | 1 | Bus request to the arbiter |
| dackN | output | 1 | Transfer acknowledge, active low |
| done | output | 1 | Transfer count exhausted |

## Verification
The bench checks the exact edge of first sampling after the enabling write. A design that sampled one cycle early or late would raise busReq at the wrong edge. It drops the request pin high while the grant is withheld, which exposes a design that passes the pin through instead of latching it. With the pin held low it measures the gap between back-to-back acknowledges: a design that reopens acceptance too early, or keeps it shut too long, shows a gap other than two cycles. Disabling writes are aimed both at a held request and at a running transfer. A design that dropped the held request late, cut a transfer short or accepted afterwards would produce a stray or truncated acknowledge pulse, or a busReq that should not be there.

// File: rtl/dmaacc_pkg.sv
package dmaacc_pkg;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_HELD = 2'd1,
    ST_XFER = 2'd2
  } accState_e;

  typedef struct packed {
    logic decCnt;
    logic xferBusy;
  } ctrlStrobe_t;

endpackage

// File: rtl/dmaacc_dpath.sv
module dmaacc_dpath
  import dmaacc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEn,
  input  logic [CNT_W-1:0] cfgCount,
  input  ctrlStrobe_t      strb,
  output logic             chanEn,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      chanEn <= 1'b0;
      done   <= 1'b0;
    end else if (cfgWr) begin
      if (cfgEn) begin
        remain <= cfgCount;
        if (cfgCount == '0) begin
          chanEn <= 1'b0;
          done   <= 1'b1;
        end else begin
          chanEn <= 1'b1;
          done   <= 1'b0;
        end
      end else begin
        chanEn <= 1'b0;
      end
    end else if (strb.decCnt && remain != '0) begin
      remain <= remain - CNT_ONE;
      if (remain == CNT_ONE) begin
        chanEn <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  // R8: a finished channel is never left enabled
  p_done_disables_r8 : assert property (@(posedge clk) disable iff (!rstN)
    done |-> !chanEn);

endmodule

// File: rtl/dmaacc_ctrl.sv
module dmaacc_ctrl
  import dmaacc_pkg::*;
#(
  parameter int XFER_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEn,
  input  logic        levelMode,
  input  logic        srcPin,
  input  logic        dreqN,
  input  logic        busGrant,
  output logic        busReq,
  output logic        dackN,
  output ctrlStrobe_t strb
);

  localparam int CYC_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(XFER_CYC - 1);

  accState_e        state, stateNxt;
  logic [CYC_W-1:0] cyc, cycNxt;
  logic             acceptOpen;

  assign acceptOpen = (state == ST_OPEN) && chanEn && levelMode && srcPin;

  always_comb begin
    stateNxt    = state;
    cycNxt      = cyc;
    strb.decCnt = 1'b0;
    unique case (state)
      ST_OPEN: begin
        if (acceptOpen && !dreqN) stateNxt = ST_HELD;
      end
      ST_HELD: begin
        if (!chanEn) begin
          stateNxt = ST_OPEN;
        end else if (busGrant) begin
          stateNxt = ST_XFER;
          cycNxt   = '0;
        end
      end
      ST_XFER: begin
        if (cyc == CYC_LAST) begin
          stateNxt    = ST_OPEN;
          strb.decCnt = 1'b1;
        end else begin
          cycNxt = cyc + 1'b1;
        end
      end
      default: stateNxt = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OPEN;
      cyc   <= '0;
    end else begin
      state <= stateNxt;
      cyc   <= cycNxt;
    end
  end

  assign busReq        = (state != ST_OPEN);
  assign dackN         = (state != ST_XFER);
  assign strb.xferBusy = (state == ST_XFER);

  // R6: acknowledge only while the bus is requested
  p_ack_under_busreq_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !dackN |-> busReq);

  // R2: a new request only follows a qualified low sample
  p_accept_qualified_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(!dreqN && chanEn && levelMode && srcPin));

  // R5: a grant on a held, still enabled request starts the transfer
  p_grant_starts_ack_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (busReq && dackN && busGrant && chanEn) |=> !dackN);

  generate
    if (XFER_CYC >= 2) begin : g_lenChk
      // R6: the acknowledge never ends after a single cycle
      p_ack_min_len_r6 : assert property (@(posedge clk) disable iff (!rstN)
        $fell(dackN) |=> !dackN);
    end
  endgenerate

endmodule

// File: rtl/dma_req_accept.sv
module dma_req_accept
  import dmaacc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int XFER_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEn,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             levelMode,
  input  logic             srcPin,
  input  logic             dreqN,
  input  logic             busGrant,
  output logic             busReq,
  output logic             dackN,
  output logic             done
);

  ctrlStrobe_t strb;
  logic        chanEn;

  dmaacc_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .cfgEn    (cfgEn),
    .cfgCount (cfgCount),
    .strb     (strb),
    .chanEn   (chanEn),
    .done     (done)
  );

  dmaacc_ctrl #(.XFER_CYC(XFER_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanEn    (chanEn),
    .levelMode (levelMode),
    .srcPin    (srcPin),
    .dreqN     (dreqN),
    .busGrant  (busGrant),
    .busReq    (busReq),
    .dackN     (dackN),
    .strb      (strb)
  );

  // R8: once finished, no bus request is outstanding
  p_done_quiet_r8 : assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq);

endmodule

// File: tb/dma_req_accept_bench.sv
module dma_req_accept_bench;

  localparam int CNT_W    = 16;
  localparam int XFER_CYC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic cfgEn = 1'b0;
  logic [CNT_W-1:0] cfgCount = '0;
  logic levelMode = 1'b1;
  logic srcPin = 1'b1;
  logic dreqN = 1'b1;
  logic busGrant = 1'b0;
  logic busReq, dackN, done;

  logic grantOn = 1'b0;
  logic checkGap = 1'b0;
  int nTests = 0;
  int nFail = 0;
  int expQ[$];
  int xferNo = 0;

  always #2 clk = ~clk;

  dma_req_accept #(.CNT_W(CNT_W), .XFER_CYC(XFER_CYC)) u_dma_req_accept (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEn(cfgEn), .cfgCount(cfgCount),
    .levelMode(levelMode), .srcPin(srcPin), .dreqN(dreqN), .busGrant(busGrant),
    .busReq(busReq), .dackN(dackN), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // arbiter model: grant follows busReq one edge later
  always @(posedge clk) begin
    #1 busGrant = grantOn && busReq;
  end

  // driver side of the scoreboard
  task automatic expectXfers(input int n);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(xferNo);
      xferNo++;
    end
  endtask

  task automatic cyclesN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // caller is at a negedge; returns at the negedge after the write edge
  task automatic wrCfg(input logic en, input int cnt);
    cfgWr    = 1'b1;
    cfgEn    = en;
    cfgCount = CNT_W'(cnt);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // monitor side of the scoreboard
  int  lowRun = 0;
  int  highRun = 0;
  bit  gapValid = 1'b0;
  logic prevDack = 1'b1;
  int  got;
  always @(negedge clk) begin
    if (rstN) begin
      if (!dackN) begin
        if (prevDack && gapValid && checkGap)
          chk(highRun == 2, "R7 gap between transfers", highRun, 2);
        lowRun++;
      end else if (!prevDack) begin
        chk(lowRun == XFER_CYC, "R6 ack length", lowRun, XFER_CYC);
        if (expQ.size() == 0) begin
          chk(1'b0, "R8 unexpected transfer", 1, 0);
        end else begin
          got = expQ.pop_front();
        end
        lowRun   = 0;
        highRun  = 1;
        gapValid = 1'b1;
      end else begin
        highRun++;
      end
      prevDack = dackN;
    end
  end

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int waitCnt;
    cyclesN(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busReq == 1'b0, "R1 busReq", busReq, 0);
    chk(dackN == 1'b1, "R1 dackN", dackN, 1);
    chk(done == 1'b0, "R1 done", done, 0);

    // R2 no sampling before enable
    dreqN = 1'b0;
    cyclesN(4);
    chk(busReq == 1'b0, "R2 disabled channel", busReq, 0);

    // R3 first sampling edge, R4 hold
    grantOn = 1'b0;
    wrCfg(1'b1, 3);
    chk(busReq == 1'b0, "R3 not at first edge", busReq, 0);
    @(negedge clk);
    chk(busReq == 1'b1, "R3 sampled at second edge", busReq, 1);
    dreqN = 1'b1;
    cyclesN(4);
    chk(busReq == 1'b1, "R4 request held", busReq, 1);
    chk(dackN == 1'b1, "R4 no ack without grant", dackN, 1);

    // R5 grant timing, R6/R7/R8 back-to-back transfers
    expectXfers(3);
    dreqN    = 1'b0;
    checkGap = 1'b1;
    grantOn  = 1'b1;
    @(negedge clk);
    chk(dackN == 1'b1, "R5 ack not before grant edge", dackN, 1);
    @(negedge clk);
    chk(dackN == 1'b0, "R5 ack after grant edge", dackN, 0);
    chk(busReq == 1'b1, "R6 busReq during ack", busReq, 1);
    waitCnt = 0;
    while (!done && waitCnt < 100) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(done == 1'b1, "R8 done after count", done, 1);
    cyclesN(6);
    checkGap = 1'b0;
    chk(busReq == 1'b0, "R8 no request after done", busReq, 0);
    chk(expQ.size() == 0, "R8 transfer count", expQ.size(), 0);

    // R12 done cleared, R10 disable while held
    grantOn = 1'b0;
    wrCfg(1'b1, 5);
    chk(done == 1'b0, "R12 done cleared", done, 0);
    @(negedge clk);
    chk(busReq == 1'b1, "R10 request held first", busReq, 1);
    wrCfg(1'b0, 0);
    @(negedge clk);
    chk(busReq == 1'b0, "R10 request dropped", busReq, 0);
    grantOn = 1'b1;
    cyclesN(6);
    chk(busReq == 1'b0, "R10 stays idle", busReq, 0);
    chk(done == 1'b0, "R10 done untouched", done, 0);

    // R11 disable during transfer
    expectXfers(1);
    wrCfg(1'b1, 5);
    waitCnt = 0;
    while (dackN && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(dackN == 1'b0, "R11 transfer started", dackN, 0);
    wrCfg(1'b0, 0);
    cyclesN(6);
    chk(busReq == 1'b0, "R11 no request after disable", busReq, 0);
    chk(expQ.size() == 0, "R11 transfer completed", expQ.size(), 0);

    // R2 mode gating
    levelMode = 1'b0;
    wrCfg(1'b1, 4);
    cyclesN(6);
    chk(busReq == 1'b0, "R2 levelMode low", busReq, 0);
    levelMode = 1'b1;
    srcPin    = 1'b0;
    cyclesN(6);
    chk(busReq == 1'b0, "R2 srcPin low", busReq, 0);
    wrCfg(1'b0, 0);
    srcPin = 1'b1;
    cyclesN(3);

    // R9 zero count
    wrCfg(1'b1, 0);
    chk(done == 1'b1, "R9 done on zero count", done, 1);
    cyclesN(5);
    chk(busReq == 1'b0, "R9 no request", busReq, 0);
    chk(expQ.size() == 0, "R9 no transfer", expQ.size(), 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule